// File: doc/BRIEF.md
# Saturating Dual 40-bit Accumulator

This block holds two 40-bit signed accumulators that share a single 41-bit adder/subtractor. Each cycle a command may be presented: it names a target accumulator, an operation code and a 40-bit operand. The operand is expected to be a value that upstream logic has already sign-extended to 40 bits, such as a 33-bit product or a shifted word. Two accumulator-to-accumulator operations use the other accumulator as the operand and need no external data. The command, the mode bits and the flag-clear request are captured in an input register. The selected accumulator is updated on the following clock edge.

Each accumulator has its own saturation enable. One shared width bit chooses between clamping at the 40-bit limits and clamping at the 32-bit (1.31) limits. When saturation is disabled for an accumulator, it runs in flag-only mode: the result wraps and only a flag records the loss. Every accumulator reports two flags. The guard overflow flag shows whether the value currently spills into the top eight guard bits. The sticky saturation flag records that a result was clamped or lost. Combined outputs OR the two accumulators' flags together for quick status polling.

Top module: `dual_acc40`

## Requirements
- R1: After reset both accumulators read zero and all six flag outputs are low.
- R2: Operation codes act on the target (cmd_sel 0 = A, 1 = B) as follows: 1 adds cmd_opd, 2 subtracts cmd_opd, 3 loads cmd_opd, 4 clears to zero and 5 negates the target. Subtraction is formed as target plus the inverted operand plus a carry-in of one.
- R3: Code 6 adds the non-target accumulator to the target, and code 7 subtracts the non-target accumulator from the target. cmd_opd is ignored for these codes.
- R4: A command sampled at clock edge k is visible on the outputs after edge k+1. Code 0, an idle cycle (cmd_valid low) and the non-target accumulator leave every accumulator value and every guard overflow flag unchanged.
- R5: After each operation, the target's guard overflow flag is high exactly when bits 39 down to 31 of the new value are not all equal.
- R6: With saturation enabled and sat_wide high, a result beyond the 40-bit signed range is clamped to 0x7FFFFFFFFF or 0x8000000000 and sets the target's saturation flag.
- R7: With saturation enabled and sat_wide low, a result beyond the 32-bit signed range is clamped to 0x007FFFFFFF or 0xFF80000000 and sets the saturation flag. The guard overflow flag is therefore never high after such an operation.
- R8: With saturation disabled for the target, the result wraps modulo 2^40. The saturation flag is set when the true result lies outside the 40-bit range.
- R9: Saturation flags are sticky. sat_clr bit i, captured with the command, clears flag i on the same update. A saturation event on that accumulator in the same update keeps the flag set.
- R10: ov_any is the OR of the two guard overflow flags, and sat_any is the OR of the two saturation flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (see R2, R3) |
| cmd_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| cmd_opd | input | 40 | Sign-extended operand |
| sat_en | input | 2 | Per-accumulator saturation enable (bit 0 = A) |
| sat_wide | input | 1 | 1 = clamp at 40 bits, 0 = clamp at 32 bits |
| sat_clr | input | 2 | Clear request for the sticky saturation flags (bit 0 = A) |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ov_a | output | 1 | Guard overflow flag, A |
| ov_b | output | 1 | Guard overflow flag, B |
| sat_a | output | 1 | Sticky saturation flag, A |
| sat_b | output | 1 | Sticky saturation flag, B |
| ov_any | output | 1 | OR of the guard overflow flags |
| sat_any | output | 1 | OR of the saturation flags |

## Verification
The properties assume that the command, mode and clear inputs are stable around each rising edge. They also assume that reset is held for several cycles with cmd_valid low, so that the two-deep history used by the properties starts from idle inputs. The stimulus meets this by changing every input only on the falling edge and by driving idle values throughout reset. Operand values are always legal 40-bit patterns. Values near both range limits are chosen on purpose so that each clamp and wrap path is reached.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

    localparam int DACC_W    = 40;
    localparam int DACC_NW   = 32;
    localparam int DACC_NACC = 2;

    typedef enum logic [2:0] {
        OPC_IDLE = 3'd0,
        OPC_ADD  = 3'd1,
        OPC_SUB  = 3'd2,
        OPC_LOAD = 3'd3,
        OPC_ZERO = 3'd4,
        OPC_NEG  = 3'd5,
        OPC_XADD = 3'd6,
        OPC_XSUB = 3'd7
    } dacc_op_e;

endpackage

// File: rtl/dacc_cmd_reg.sv
module dacc_cmd_reg
    import dacc_pkg::*;
#(
    parameter int W    = 40,
    parameter int NACC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      in_op,
    input  logic            in_sel,
    input  logic [W-1:0]    in_opd,
    input  logic [NACC-1:0] in_en,
    input  logic            in_wide,
    input  logic [NACC-1:0] in_clr,
    output logic            q_valid,
    output dacc_op_e        q_op,
    output logic            q_sel,
    output logic [W-1:0]    q_opd,
    output logic [NACC-1:0] q_en,
    output logic            q_wide,
    output logic [NACC-1:0] q_clr
);

    typedef struct packed {
        logic            valid;
        dacc_op_e        op;
        logic            sel;
        logic [W-1:0]    opd;
        logic [NACC-1:0] en;
        logic            wide;
        logic [NACC-1:0] clr;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d       = cmd_q;
        cmd_d.valid = in_valid;
        cmd_d.op    = dacc_op_e'(in_op);
        cmd_d.sel   = in_sel;
        cmd_d.opd   = in_opd;
        cmd_d.en    = in_en;
        cmd_d.wide  = in_wide;
        cmd_d.clr   = in_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign q_valid = cmd_q.valid;
    assign q_op    = cmd_q.op;
    assign q_sel   = cmd_q.sel;
    assign q_opd   = cmd_q.opd;
    assign q_en    = cmd_q.en;
    assign q_wide  = cmd_q.wide;
    assign q_clr   = cmd_q.clr;

endmodule

// File: rtl/dacc_addsub.sv
module dacc_addsub #(
    parameter int W = 40
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         sub,
    output logic [W:0]   sum
);

    logic [W:0] a_ext;
    logic [W:0] b_ext;
    logic [W:0] b_eff;
    logic [W:0] cin;

    always_comb begin
        a_ext = {opa[W-1], opa};
        b_ext = {opb[W-1], opb};
        // borrow is active low: subtract feeds inverted operand and carry 1
        b_eff = sub ? ~b_ext : b_ext;
        cin   = {{W{1'b0}}, sub};
        sum   = a_ext + b_eff + cin;
    end

endmodule

// File: rtl/dacc_limit.sv
module dacc_limit #(
    parameter int W  = 40,
    parameter int NW = 32
) (
    input  logic [W:0]   sum,
    input  logic         sat_on,
    input  logic         wide,
    output logic [W-1:0] value,
    output logic         guard_ov,
    output logic         sat_evt
);

    localparam int HI_N = W - NW + 1;

    logic         wide_ovf;
    logic         narrow_ovf;
    logic [W-1:0] pos_wide;
    logic [W-1:0] neg_wide;
    logic [W-1:0] pos_narrow;
    logic [W-1:0] neg_narrow;
    logic [HI_N-1:0] top_bits;

    always_comb begin
        pos_wide   = {1'b0, {(W-1){1'b1}}};
        neg_wide   = {1'b1, {(W-1){1'b0}}};
        pos_narrow = {{HI_N{1'b0}}, {(NW-1){1'b1}}};
        neg_narrow = {{HI_N{1'b1}}, {(NW-1){1'b0}}};

        wide_ovf   = sum[W] ^ sum[W-1];
        narrow_ovf = !((&sum[W:NW-1]) || !(|sum[W:NW-1]));

        value   = sum[W-1:0];
        sat_evt = 1'b0;

        if (sat_on && !wide) begin
            if (narrow_ovf) begin
                value   = sum[W] ? neg_narrow : pos_narrow;
                sat_evt = 1'b1;
            end
        end else if (sat_on) begin
            if (wide_ovf) begin
                value   = sum[W] ? neg_wide : pos_wide;
                sat_evt = 1'b1;
            end
        end else begin
            sat_evt = wide_ovf;
        end

        top_bits = value[W-1:NW-1];
        guard_ov = !((&top_bits) || !(|top_bits));
    end

endmodule

// File: rtl/dual_acc40.sv
module dual_acc40
    import dacc_pkg::*;
#(
    parameter int ACC_W    = DACC_W,
    parameter int NARROW_W = DACC_NW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic             cmd_sel,
    input  logic [ACC_W-1:0] cmd_opd,
    input  logic [1:0]       sat_en,
    input  logic             sat_wide,
    input  logic [1:0]       sat_clr,
    output logic [ACC_W-1:0] acc_a,
    output logic [ACC_W-1:0] acc_b,
    output logic             ov_a,
    output logic             ov_b,
    output logic             sat_a,
    output logic             sat_b,
    output logic             ov_any,
    output logic             sat_any
);

    localparam int NACC = DACC_NACC;

    typedef struct packed {
        logic [NACC-1:0][ACC_W-1:0] acc;
        logic [NACC-1:0]            ov;
        logic [NACC-1:0]            sat;
    } state_t;

    state_t st_d, st_q;

    logic             c_valid;
    dacc_op_e         c_op;
    logic             c_sel;
    logic [ACC_W-1:0] c_opd;
    logic [NACC-1:0]  c_en;
    logic             c_wide;
    logic [NACC-1:0]  c_clr;

    logic [ACC_W-1:0] add_a;
    logic [ACC_W-1:0] add_b;
    logic             add_sub;
    logic [ACC_W:0]   add_sum;
    logic [ACC_W-1:0] lim_val;
    logic             lim_ov;
    logic             lim_sat;
    logic [ACC_W-1:0] tgt_val;
    logic [ACC_W-1:0] oth_val;
    logic             writes;

    dacc_cmd_reg #(.W(ACC_W), .NACC(NACC)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (cmd_valid),
        .in_op    (cmd_op),
        .in_sel   (cmd_sel),
        .in_opd   (cmd_opd),
        .in_en    (sat_en),
        .in_wide  (sat_wide),
        .in_clr   (sat_clr),
        .q_valid  (c_valid),
        .q_op     (c_op),
        .q_sel    (c_sel),
        .q_opd    (c_opd),
        .q_en     (c_en),
        .q_wide   (c_wide),
        .q_clr    (c_clr)
    );

    // operand steering for the shared adder
    always_comb begin
        tgt_val = st_q.acc[c_sel];
        oth_val = st_q.acc[!c_sel];
        add_a   = tgt_val;
        add_b   = c_opd;
        add_sub = 1'b0;
        unique case (c_op)
            OPC_ADD:  begin add_a = tgt_val; add_b = c_opd;   add_sub = 1'b0; end
            OPC_SUB:  begin add_a = tgt_val; add_b = c_opd;   add_sub = 1'b1; end
            OPC_LOAD: begin add_a = '0;      add_b = c_opd;   add_sub = 1'b0; end
            OPC_ZERO: begin add_a = '0;      add_b = '0;      add_sub = 1'b0; end
            OPC_NEG:  begin add_a = '0;      add_b = tgt_val; add_sub = 1'b1; end
            OPC_XADD: begin add_a = tgt_val; add_b = oth_val; add_sub = 1'b0; end
            OPC_XSUB: begin add_a = tgt_val; add_b = oth_val; add_sub = 1'b1; end
            default:  begin add_a = tgt_val; add_b = '0;      add_sub = 1'b0; end
        endcase
    end

    dacc_addsub #(.W(ACC_W)) u_add (
        .opa (add_a),
        .opb (add_b),
        .sub (add_sub),
        .sum (add_sum)
    );

    dacc_limit #(.W(ACC_W), .NW(NARROW_W)) u_lim (
        .sum      (add_sum),
        .sat_on   (c_en[c_sel]),
        .wide     (c_wide),
        .value    (lim_val),
        .guard_ov (lim_ov),
        .sat_evt  (lim_sat)
    );

    always_comb begin
        st_d   = st_q;
        writes = c_valid && (c_op != OPC_IDLE);
        for (int i = 0; i < NACC; i++) begin
            st_d.sat[i] = st_q.sat[i] & ~c_clr[i];
            if (writes && (int'(c_sel) == i)) begin
                st_d.acc[i] = lim_val;
                st_d.ov[i]  = lim_ov;
                if (lim_sat) begin
                    st_d.sat[i] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_a   = st_q.acc[0];
    assign acc_b   = st_q.acc[1];
    assign ov_a    = st_q.ov[0];
    assign ov_b    = st_q.ov[1];
    assign sat_a   = st_q.sat[0];
    assign sat_b   = st_q.sat[1];
    assign ov_any  = |st_q.ov;
    assign sat_any = |st_q.sat;

endmodule

// File: rtl/dual_acc40_chk.sv
module dual_acc40_chk #(
    parameter int ACC_W    = 40,
    parameter int NARROW_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             cmd_sel,
    input logic [1:0]       sat_en,
    input logic             sat_wide,
    input logic [1:0]       sat_clr,
    input logic [ACC_W-1:0] acc_a,
    input logic [ACC_W-1:0] acc_b,
    input logic             ov_a,
    input logic             ov_b,
    input logic             sat_a,
    input logic             sat_b
);

    logic hit_a;
    logic hit_b;
    assign hit_a = cmd_valid && !cmd_sel && (cmd_op != 3'd0);
    assign hit_b = cmd_valid &&  cmd_sel && (cmd_op != 3'd0);

    // R4: untouched accumulator holds its value
    assert_hold_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hit_a, 2) |-> $stable(acc_a));
    assert_hold_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hit_b, 2) |-> $stable(acc_b));

    // R5: guard flag only changes on an operation for that accumulator
    assert_ov_hold_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hit_a, 2) |-> $stable(ov_a));

    // R7: narrow clamping keeps the guard bits as pure sign copies
    assert_narrow_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit_a && sat_en[0] && !sat_wide, 2) |->
        (!ov_a && ((&acc_a[ACC_W-1:NARROW_W-1]) || !(|acc_a[ACC_W-1:NARROW_W-1]))));

    // R9: sticky flags fall only after a clear request
    assert_sat_fall_a_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sat_a) |-> $past(sat_clr[0], 2));
    assert_sat_fall_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sat_b) |-> $past(sat_clr[1], 2));

    // R9: a flag rises only from an operation on its accumulator
    assert_sat_rise_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sat_b) |-> $past(hit_b, 2));

endmodule

bind dual_acc40 dual_acc40_chk #(.ACC_W(ACC_W), .NARROW_W(NARROW_W)) u_chk (.*);

// File: tb/dual_acc40_test.sv
module dual_acc40_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic        cmd_sel = 1'b0;
    logic [39:0] cmd_opd = '0;
    logic [1:0]  sat_en = '0;
    logic        sat_wide = 1'b0;
    logic [1:0]  sat_clr = '0;
    logic [39:0] acc_a, acc_b;
    logic        ov_a, ov_b, sat_a, sat_b, ov_any, sat_any;

    dual_acc40 uut (.*);

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        int           due;
        logic [85:0]  exp;
        string        tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model state
    logic [39:0] ma = '0, mb = '0;
    bit oa = 0, ob = 0, sa = 0, sb = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [85:0] pack_obs();
        return {acc_a, acc_b, ov_a, ov_b, sat_a, sat_b, ov_any, sat_any};
    endfunction

    function automatic logic [85:0] pack_exp();
        return {ma, mb, oa, ob, sa, sb, oa | ob, sa | sb};
    endfunction

    task automatic issue(input logic [2:0] op, input bit sel, input logic [39:0] opd,
                         input logic [1:0] en, input bit wide, input logic [1:0] clr,
                         input string tag);
        longint t, o, r;
        longint mx, mn;
        logic [63:0] raw;
        bit s_evt;
        bit en_t;
        item_t it;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel; cmd_opd = opd;
        sat_en = en; sat_wide = wide; sat_clr = clr;
        t = sel ? $signed(mb) : $signed(ma);
        o = sel ? $signed(ma) : $signed(mb);
        case (op)
            3'd1: r = t + $signed(opd);
            3'd2: r = t - $signed(opd);
            3'd3: r = $signed(opd);
            3'd4: r = 0;
            3'd5: r = -t;
            3'd6: r = t + o;
            3'd7: r = t - o;
            default: r = t;
        endcase
        en_t = sel ? en[1] : en[0];
        s_evt = 0;
        if (en_t && !wide) begin
            mx = 64'sd2147483647; mn = -64'sd2147483648;
            if (r > mx) begin r = mx; s_evt = 1; end
            if (r < mn) begin r = mn; s_evt = 1; end
        end else if (en_t) begin
            mx = 64'sd549755813887; mn = -64'sd549755813888;
            if (r > mx) begin r = mx; s_evt = 1; end
            if (r < mn) begin r = mn; s_evt = 1; end
        end else begin
            if (r > 64'sd549755813887 || r < -64'sd549755813888) s_evt = 1;
        end
        raw = r;
        if (clr[0]) sa = 0;
        if (clr[1]) sb = 0;
        if (op != 3'd0) begin
            r = $signed(raw[39:0]);
            if (sel) begin
                mb = raw[39:0]; ob = (r > 64'sd2147483647 || r < -64'sd2147483648);
                if (s_evt) sb = 1;
            end else begin
                ma = raw[39:0]; oa = (r > 64'sd2147483647 || r < -64'sd2147483648);
                if (s_evt) sa = 1;
            end
        end
        it.due = cyc + 2;
        it.exp = pack_exp();
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle_cycle(input logic [1:0] clr, input string tag);
        item_t it;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd1; cmd_opd = 40'h12345; sat_clr = clr;
        if (clr[0]) sa = 0;
        if (clr[1]) sb = 0;
        it.due = cyc + 2; it.exp = pack_exp(); it.tag = tag;
        q.push_back(it);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [85:0] obs;
                it = q.pop_front();
                obs = pack_obs();
                n_chk++;
                if (obs !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, obs, it.exp);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (pack_obs() !== 86'd0) begin
            n_bad++;
            $display("FAIL R1 reset: actual %h expected %h", pack_obs(), 86'd0);
        end
        // R2 basic operations, saturation wide on both
        issue(3'd3, 0, 40'd5,   2'b11, 1, 2'b00, "R2 load A");
        issue(3'd3, 1, 40'd3,   2'b11, 1, 2'b00, "R2 load B");
        issue(3'd1, 0, 40'd100, 2'b11, 1, 2'b00, "R2 add A");
        issue(3'd2, 1, 40'd10,  2'b11, 1, 2'b00, "R2 sub B");
        issue(3'd5, 1, 40'd0,   2'b11, 1, 2'b00, "R2 negate B");
        // R3 accumulator to accumulator
        issue(3'd6, 0, 40'hFFFFFFFFFF, 2'b11, 1, 2'b00, "R3 A+=B");
        issue(3'd7, 1, 40'd77,  2'b11, 1, 2'b00, "R3 B-=A");
        // R4 no-op and idle
        issue(3'd0, 0, 40'd999, 2'b11, 1, 2'b00, "R4 nop");
        idle_cycle(2'b00, "R4 idle");
        // R5 guard overflow set then refreshed
        issue(3'd3, 0, 40'h0100000000, 2'b11, 1, 2'b00, "R5 guard set");
        issue(3'd1, 1, 40'd1,   2'b11, 1, 2'b00, "R5 other acc keeps A flag");
        issue(3'd3, 0, 40'h0000001000, 2'b11, 1, 2'b00, "R5 guard refresh");
        issue(3'd3, 0, 40'hFF7FFFFFFF, 2'b11, 1, 2'b00, "R5 negative guard");
        // R6 40-bit saturation
        issue(3'd3, 0, 40'h7FFFFFFF00, 2'b11, 1, 2'b00, "R6 load near max");
        issue(3'd1, 0, 40'h0000000200, 2'b11, 1, 2'b00, "R6 positive clamp");
        issue(3'd3, 1, 40'h8000000010, 2'b11, 1, 2'b00, "R6 load near min");
        issue(3'd2, 1, 40'h0000000100, 2'b11, 1, 2'b00, "R6 negative clamp");
        // R9 sticky then clear
        issue(3'd3, 0, 40'd1, 2'b11, 1, 2'b00, "R9 sticky stays");
        idle_cycle(2'b01, "R9 clear A");
        issue(3'd1, 1, 40'hFFFFFFFFFF, 2'b11, 1, 2'b10, "R9 set wins over clear");
        idle_cycle(2'b10, "R9 clear B");
        // R7 32-bit saturation
        issue(3'd3, 0, 40'h007FFFFFF0, 2'b11, 0, 2'b00, "R7 load near max32");
        issue(3'd1, 0, 40'h0000000100, 2'b11, 0, 2'b00, "R7 positive clamp");
        issue(3'd3, 1, 40'hFF80000000, 2'b11, 0, 2'b00, "R7 load min32");
        issue(3'd2, 1, 40'd1, 2'b11, 0, 2'b00, "R7 negative clamp");
        issue(3'd3, 0, 40'h4000000000, 2'b11, 0, 2'b11, "R7 load clamps, no guard flag");
        // R8 flag-only wrap
        issue(3'd3, 0, 40'h7FFFFFFFFF, 2'b00, 1, 2'b11, "R8 load max");
        issue(3'd1, 0, 40'd1, 2'b00, 1, 2'b00, "R8 wrap positive");
        issue(3'd3, 1, 40'h8000000000, 2'b00, 0, 2'b00, "R8 load min");
        issue(3'd5, 1, 40'd0, 2'b00, 0, 2'b00, "R8 negate min wraps");
        // R10 combined status
        issue(3'd4, 0, 40'd0, 2'b11, 1, 2'b01, "R10 clear A, B flags remain");
        issue(3'd4, 1, 40'd0, 2'b11, 1, 2'b10, "R10 all low");
        repeat (4) idle_cycle(2'b00, "R4 drain");
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule